// File: doc/BRIEF.md
# Bank-Selected Input/Output Bias Adder

This block is a pipelined offset stage for a multi-lane 13-bit video path. It has two independent sections, a pre section that sits ahead of the colour arithmetic and a post section that sits after it. Each section adds a bias constant to every lane of the sample word passing through it. The section registers the result, so the output follows one clock later. The arithmetic between the two sections is not part of this block.

Each section owns a bank of four programmable bias registers. A 2-bit select input per section chooses which register applies to the sample presented on the same cycle, so the offset can be switched from one sample to the next. A configuration word carries one disable bit per section. When a section's bit is set, that section adds zero. A simple write port (strobe, 3-bit address, 13-bit data) loads the eight bias registers. A separate strobe loads the configuration word.

Top module: `vbias_adder`

## Requirements
- R1: In each section, select code 0, 1, 2 or 3 applies bias register 0, 1, 2 or 3 of that section's bank.
- R2: A select value may change on every cycle. Each sample uses the select value presented in the same cycle as that sample.
- R3: The pre select and the post select are independent. Each one affects only its own section.
- R4: The result for a sample appears on the section output exactly one clock edge after the sample is presented.
- R5: Write address 0..3 loads pre bias registers 0..3, and address 4..7 loads post bias registers 0..3. A sample presented in the strobe cycle still uses the old value. A sample presented in the cycle after the strobe uses the new value.
- R6: Configuration data bit 11 disables the pre bias and bit 12 disables the post bias, each independently. A disabled section outputs its input unchanged. A configuration write takes effect for samples presented from the cycle after its strobe.
- R7: Samples and biases are 13-bit two's complement. A sum above 4095 gives 4095, and a sum below -4096 gives -4096.
- R8: While reset is asserted, both outputs are zero. Reset clears all eight bias registers and both disable bits, so samples pass through unchanged after reset.
- R9: Within a section, the same selected bias is added to every lane. Lane k occupies bits [13k+12:13k].
- R10: When the write strobe is low, the address and data inputs have no effect on any bias register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pre_data_i | input | 39 | Pre section sample word, three 13-bit lanes |
| pre_sel_i | input | 2 | Pre section bias register select |
| pre_data_o | output | 39 | Pre section result, registered |
| post_data_i | input | 39 | Post section sample word, three 13-bit lanes |
| post_sel_i | input | 2 | Post section bias register select |
| post_data_o | output | 39 | Post section result, registered |
| wr_en_i | input | 1 | Bias register write strobe |
| wr_addr_i | input | 3 | Bias register address, 0..3 pre and 4..7 post |
| wr_data_i | input | 13 | Bias value to write |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 16 | Configuration word; bit 11 disables pre, bit 12 disables post |

## Verification
Every section result is due one clock edge after its sample, select and disable state are presented. Bias and configuration writes change only the results of samples presented from the following cycle on. The bench drives each cycle's inputs at the falling edge. At that moment it computes the expected result from its own model state as it stood before that cycle's writes, and only then applies those writes to the model. It compares the outputs at the next falling edge, half a period after the register captures them. Because of this ordering, a sample that coincides with a write is checked against the old bias.

// File: rtl/vbias_pkg.sv
package vbias_pkg;

  typedef enum logic {
    SEC_PRE  = 1'b0,
    SEC_POST = 1'b1
  } sec_e;

  localparam int unsigned NUM_SEC          = 2;
  localparam int unsigned CFG_PRE_DIS_BIT  = 11;
  localparam int unsigned CFG_POST_DIS_BIT = 12;

endpackage

// File: rtl/vbias_bank.sv
module vbias_bank #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [SW-1:0]    sel_i,
  output logic [W-1:0]     bias_o
);

  logic [DEPTH-1:0][W-1:0] bank_d, bank_q;

  always_comb begin
    bank_d = bank_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (we_i[i]) bank_d[i] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= '0;
    else         bank_q <= bank_d;
  end

  assign bias_o = bank_q[sel_i];

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) == '0) |-> $stable(bank_q)); // R10

endmodule

// File: rtl/vbias_lane.sv
module vbias_lane #(
  parameter int unsigned W = 13
) (
  input  logic [W-1:0] smp_i,
  input  logic [W-1:0] bias_i,
  output logic [W-1:0] sum_o
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic [W:0] wide;

  always_comb begin
    wide = {smp_i[W-1], smp_i} + {bias_i[W-1], bias_i};
    if (wide[W] != wide[W-1]) sum_o = wide[W] ? MINV : MAXV;
    else                      sum_o = wide[W-1:0];
  end

endmodule

// File: rtl/vbias_section.sv
module vbias_section #(
  parameter int unsigned W     = 13,
  parameter int unsigned LANES = 3,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned SW   = $clog2(DEPTH),
  localparam int unsigned DW   = W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] we_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [SW-1:0]    sel_i,
  input  logic             dis_i,
  input  logic [DW-1:0]    data_i,
  output logic [DW-1:0]    data_o
);

  logic [W-1:0]  bias_sel;
  logic [W-1:0]  bias_eff;
  logic [DW-1:0] out_d, out_q;

  vbias_bank #(.W(W), .DEPTH(DEPTH)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .sel_i   (sel_i),
    .bias_o  (bias_sel)
  );

  assign bias_eff = dis_i ? '0 : bias_sel;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vbias_lane #(.W(W)) u_lane (
      .smp_i  (data_i[k*W +: W]),
      .bias_i (bias_eff),
      .sum_o  (out_d[k*W +: W])
    );

    AST_NO_WRAP_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(!data_i[k*W+W-1] && !bias_eff[W-1]) |-> !out_q[k*W+W-1]); // R7
    AST_NO_WRAP_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(data_i[k*W+W-1] && bias_eff[W-1]) |-> out_q[k*W+W-1]); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign data_o = out_q;

  AST_DIS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dis_i) |-> (out_q == $past(data_i))); // R6

endmodule

// File: rtl/vbias_adder.sv
module vbias_adder
  import vbias_pkg::*;
#(
  parameter int unsigned W     = 13,
  parameter int unsigned LANES = 3,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CFG_W = 16,
  localparam int unsigned SW   = $clog2(DEPTH),
  localparam int unsigned AW   = $clog2(NUM_SEC * DEPTH),
  localparam int unsigned DW   = W * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    pre_data_i,
  input  logic [SW-1:0]    pre_sel_i,
  output logic [DW-1:0]    pre_data_o,
  input  logic [DW-1:0]    post_data_i,
  input  logic [SW-1:0]    post_sel_i,
  output logic [DW-1:0]    post_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_data_i
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  // configuration disable bits
  logic [NUM_SEC-1:0] dis_d, dis_q;

  always_comb begin
    dis_d = dis_q;
    if (cfg_we_i) begin
      dis_d[SEC_PRE]  = cfg_data_i[CFG_PRE_DIS_BIT];
      dis_d[SEC_POST] = cfg_data_i[CFG_POST_DIS_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) dis_q <= '0;
    else            dis_q <= dis_d;
  end

  // write decode
  logic [NUM_SEC-1:0][DEPTH-1:0] sec_we;

  always_comb begin
    for (int s = 0; s < NUM_SEC; s++) begin
      for (int i = 0; i < DEPTH; i++) begin
        sec_we[s][i] = wr_en_i && (wr_addr_i == AW'(s * DEPTH + i));
      end
    end
  end

  AST_WE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    $onehot0(sec_we) && (wr_en_i == (sec_we != '0))); // R5

  // sections
  logic [NUM_SEC-1:0][DW-1:0] sec_in, sec_out;
  logic [NUM_SEC-1:0][SW-1:0] sec_sel;

  assign sec_in[SEC_PRE]   = pre_data_i;
  assign sec_in[SEC_POST]  = post_data_i;
  assign sec_sel[SEC_PRE]  = pre_sel_i;
  assign sec_sel[SEC_POST] = post_sel_i;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    vbias_section #(.W(W), .LANES(LANES), .DEPTH(DEPTH)) u_sec (
      .clk_i   (clk_i),
      .rst_ni  (rst_int_n),
      .we_i    (sec_we[s]),
      .wdata_i (wr_data_i),
      .sel_i   (sec_sel[s]),
      .dis_i   (dis_q[s]),
      .data_i  (sec_in[s]),
      .data_o  (sec_out[s])
    );
  end

  assign pre_data_o  = sec_out[SEC_PRE];
  assign post_data_o = sec_out[SEC_POST];

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_int_n |=> (!rst_int_n -> (pre_data_o == '0 && post_data_o == '0))); // R8

endmodule

// File: tb/vbias_adder_bench.sv
module vbias_adder_bench;

  localparam int W = 13;
  localparam int L = 3;
  localparam int DW = W * L;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] pre_in, post_in;
  logic [1:0]    pre_sel, post_sel;
  logic [DW-1:0] pre_out, post_out;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [W-1:0]  wr_data;
  logic          cfg_we;
  logic [15:0]   cfg_data;

  always #2ns clk = ~clk;

  vbias_adder u_vbias_adder (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pre_data_i  (pre_in),
    .pre_sel_i   (pre_sel),
    .pre_data_o  (pre_out),
    .post_data_i (post_in),
    .post_sel_i  (post_sel),
    .post_data_o (post_out),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .cfg_we_i    (cfg_we),
    .cfg_data_i  (cfg_data)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [W-1:0] mbias [8];
  logic         mdis [2];

  function automatic logic [W-1:0] sat_add(logic [W-1:0] a, logic [W-1:0] b);
    int s;
    s = int'($signed(a)) + int'($signed(b));
    if (s > 4095) s = 4095;
    if (s < -4096) s = -4096;
    return W'(s);
  endfunction

  function automatic logic [DW-1:0] model_sec(int sec, logic [DW-1:0] d, logic [1:0] sel);
    logic [DW-1:0] r;
    logic [W-1:0] b;
    b = mdis[sec] ? '0 : mbias[sec*4 + int'(sel)];
    for (int k = 0; k < L; k++) r[k*W +: W] = sat_add(d[k*W +: W], b);
    return r;
  endfunction

  task automatic cmp(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    for (int k = 0; k < L; k++) begin
      checks++;
      if (got[k*W +: W] !== exp[k*W +: W]) begin
        errs++;
        $display("FAIL %s %s lane %0d: got %0d exp %0d", tag, what, k,
                 $signed(got[k*W +: W]), $signed(exp[k*W +: W]));
      end
    end
  endtask

  // expected results from the current inputs, then model writes, then compare one edge later
  task automatic tick(string tag);
    logic [DW-1:0] e_pre, e_post;
    e_pre  = model_sec(0, pre_in, pre_sel);
    e_post = model_sec(1, post_in, post_sel);
    if (wr_en) mbias[wr_addr] = wr_data;
    if (cfg_we) begin
      mdis[0] = cfg_data[11];
      mdis[1] = cfg_data[12];
    end
    @(negedge clk);
    cmp(tag, "pre", pre_out, e_pre);
    cmp(tag, "post", post_out, e_post);
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; cfg_we = 1'b0; cfg_data = '0;
  endtask

  function automatic logic [DW-1:0] fill(logic [W-1:0] v);
    return {L{v}};
  endfunction

  function automatic logic [W-1:0] rnd_val();
    int r;
    r = int'($urandom_range(0, 9));
    if (r == 0) return 13'h0FFF;
    if (r == 1) return 13'h1000;
    return W'($urandom);
  endfunction

  initial begin
    #(4ns * 150000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) mbias[i] = '0;
    mdis[0] = 1'b0; mdis[1] = 1'b0;
    rst_n = 1'b0;
    idle();
    pre_in = fill(13'd77); post_in = fill(13'h1F00);
    pre_sel = 2'd1; post_sel = 2'd3;
    repeat (3) @(negedge clk);
    cmp("R8", "pre reset", pre_out, '0);
    cmp("R8", "post reset", post_out, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // after reset: pass-through for every select
    for (int s = 0; s < 4; s++) begin
      pre_sel = 2'(s); post_sel = 2'(3 - s);
      pre_in = {13'd5, 13'h1FFF, 13'(s)};
      tick("R8");
    end

    // R5: write lands on the next sample, not the one in the strobe cycle
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = 13'd100;
    pre_sel = 2'd2; pre_in = fill(13'd10);
    tick("R5");
    wr_addr = 3'd6; wr_data = 13'h1FF0;
    tick("R5");
    idle(); post_sel = 2'd2; post_in = fill(13'd40);
    tick("R5");

    // R10: address and data without strobe
    wr_addr = 3'd2; wr_data = 13'd999;
    tick("R10");
    wr_addr = 3'd6;
    tick("R10");
    idle();

    // R1 R3: load distinct values, sweep selects in opposite orders
    for (int a = 0; a < 8; a++) begin
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = 13'(a * 11 + 1);
      tick("R5");
    end
    idle();
    for (int s = 0; s < 4; s++) begin
      pre_sel = 2'(s); post_sel = 2'(3 - s);
      pre_in = {13'd300, 13'd200, 13'd100}; post_in = fill(13'd0);
      tick("R1 R3");
    end

    // R7: saturation at both ends
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 13'h0FFF; tick("R5");
    wr_addr = 3'd4; wr_data = 13'h1000; tick("R5");
    idle();
    pre_sel = 2'd0; post_sel = 2'd0;
    pre_in = {13'h0FFF, 13'd1, 13'h1000};
    post_in = {13'h1FFF, 13'h1000, 13'h0FFF};
    tick("R7");

    // R6: disable each section in turn; config strobe cycle uses old state
    cfg_we = 1'b1; cfg_data = 16'h0800; tick("R6");
    idle(); tick("R6");
    cfg_we = 1'b1; cfg_data = 16'h1000; tick("R6");
    idle(); tick("R6");
    cfg_we = 1'b1; cfg_data = 16'h1800; tick("R6");
    idle(); tick("R6");
    cfg_we = 1'b1; cfg_data = 16'hE7FF; tick("R6");
    idle(); tick("R6");

    // random phase
    for (int n = 0; n < 3000; n++) begin
      pre_sel = 2'($urandom); post_sel = 2'($urandom);
      for (int k = 0; k < L; k++) begin
        pre_in[k*W +: W] = rnd_val();
        post_in[k*W +: W] = rnd_val();
      end
      wr_en = ($urandom_range(0, 4) == 0);
      wr_addr = 3'($urandom); wr_data = rnd_val();
      cfg_we = ($urandom_range(0, 9) == 0);
      cfg_data = 16'($urandom);
      tick("R1 R2 R3 R4 R5 R9");
    end
    idle();
    tick("R4");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule